// File: doc/BRIEF.md
# Page Attribute Type Combiner

This block resolves the memory type of a page access. It holds an eight-field page attribute register. A write port loads that register, and the port checks every field before it accepts the write. On each lookup the block takes the flag bits of a page-table entry together with a memory type derived from an address range. From the three caching-related flag bits it forms a 3-bit attribute index and selects the matching 8-bit field of the register, which is the page type. It then merges the page type with the range type through a fixed precedence table to give the effective memory type.

A lookup is a single-cycle strobe. Both results appear on registered outputs one clock later. The outputs keep their values until the next lookup. Page-table walking and the range-type lookup happen outside this block.

Type encodings used throughout: 0 = uncached (UC), 1 = write-combining (WC), 2 and 3 = reserved, 4 = write-through (WT), 5 = write-protect (WP), 6 = write-back (WB), 7 = weak uncached (UC-).

Top module: `pat_combiner`

## Requirements
- R1: The attribute index is formed from flag bits as follows: index bit 0 = `pteFlags[3]`, index bit 1 = `pteFlags[4]`, index bit 2 = `pteFlags[7]`. All other flag bits have no effect on either output.
- R2: The page type output equals register field n (bits 8n+7:8n of the register) for attribute index n.
- R3: After reset the fields 0..7 hold 6, 4, 7, 0, 6, 4, 7, 0, and `outValid`, `pageType` and `effType` are all 0.
- R4: A write is accepted only when all eight bytes are in {0, 1, 4, 5, 6, 7}. Otherwise the whole register keeps its previous value.
- R5: With range type UC (0), the effective type is WC (1) for a WC page type and UC (0) for every other valid page type.
- R6: With range type WC (1), the effective type is WC for page types WC, WB or UC-, and UC for UC, WT or WP.
- R7: With range type WT (4), page types WT or WB give WT, WP gives WP, WC gives WC, and UC or UC- give UC.
- R8: With range type WP (5), WB gives WP, UC- gives WC, and UC, WC, WT and WP are passed through unchanged.
- R9: With range type WB (6), the page type is passed through, except that UC- (7) becomes UC (0).
- R10: Range types 2, 3 or 7, or a page type of 2, 3 or above 7, give the effective type 2.
- R11: `outValid` is high exactly in the cycle after a cycle with `lookupValid` high. When no lookup is issued, `pageType` and `effType` hold their values.
- R12: A lookup issued in the same cycle as an accepted write uses the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the attribute register |
| wrData | input | 64 | New register contents, field n in bits 8n+7:8n |
| lookupValid | input | 1 | Lookup strobe |
| pteFlags | input | 8 | Page-table entry flag bits |
| rangeType | input | 3 | Memory type from the range lookup |
| outValid | output | 1 | Results are valid this cycle |
| pageType | output | 8 | Selected attribute field |
| effType | output | 8 | Merged effective memory type |

## Verification
The hardest case to reach from the ports is the ordering of a lookup and a write in the same cycle. The register changes at the very edge that captures the lookup result, so a design that bypasses the new data would show the wrong page type for only that one result. The stimulus raises `wrEn` and `lookupValid` in the same cycle, using a write that replaces the selected field. It checks the old field value on the outputs and then the new value on the following lookup. A rejected write leaves no trace of its own, so the bench follows each illegal write with lookups of the fields it tried to change. The bench also sweeps every range type against every index of a known register image, with unused flag bits set to noise.

// File: rtl/pat_combiner_pkg.sv
package pat_combiner_pkg;

  localparam int TYPE_W     = 8;
  localparam int NUM_FIELDS = 8;
  localparam int IDX_W      = $clog2(NUM_FIELDS);
  localparam int REG_W      = TYPE_W * NUM_FIELDS;
  localparam int RANGE_W    = 3;

  typedef enum logic [RANGE_W-1:0] {
    MT_UC   = 3'd0,
    MT_WC   = 3'd1,
    MT_RSV2 = 3'd2,
    MT_RSV3 = 3'd3,
    MT_WT   = 3'd4,
    MT_WP   = 3'd5,
    MT_WB   = 3'd6,
    MT_UCM  = 3'd7
  } memCode_e;

  typedef struct packed {
    logic attrWrite;
    logic resultLoad;
  } ctrlStrobe_t;

  function automatic logic typeWritable(input logic [TYPE_W-1:0] v);
    return (v == TYPE_W'(MT_UC)) || (v == TYPE_W'(MT_WC)) ||
           (v == TYPE_W'(MT_WT)) || (v == TYPE_W'(MT_WP)) ||
           (v == TYPE_W'(MT_WB)) || (v == TYPE_W'(MT_UCM));
  endfunction

  function automatic logic [TYPE_W-1:0] mergeTypes(
      input logic [RANGE_W-1:0] rangeCode,
      input logic [TYPE_W-1:0]  pageVal);
    memCode_e rc;
    memCode_e pc;
    memCode_e res;
    logic     rsv;
    rc  = memCode_e'(rangeCode);
    pc  = memCode_e'(pageVal[RANGE_W-1:0]);
    rsv = (|pageVal[TYPE_W-1:RANGE_W]) ||
          (pc == MT_RSV2) || (pc == MT_RSV3) ||
          (rc == MT_RSV2) || (rc == MT_RSV3) || (rc == MT_UCM);
    res = MT_RSV2;
    if (!rsv) begin
      unique case (rc)
        MT_UC:   res = (pc == MT_WC) ? MT_WC : MT_UC;
        MT_WC:   res = (pc == MT_WC || pc == MT_WB || pc == MT_UCM) ? MT_WC : MT_UC;
        MT_WT: begin
          unique case (pc)
            MT_WT, MT_WB: res = MT_WT;
            MT_WP:        res = MT_WP;
            MT_WC:        res = MT_WC;
            default:      res = MT_UC;
          endcase
        end
        MT_WP: begin
          unique case (pc)
            MT_WB:   res = MT_WP;
            MT_UCM:  res = MT_WC;
            default: res = pc;
          endcase
        end
        default: res = (pc == MT_UCM) ? MT_UC : pc;
      endcase
    end
    return TYPE_W'(res);
  endfunction

endpackage

// File: rtl/pat_combiner_ctrl.sv
module pat_combiner_ctrl
  import pat_combiner_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrLegal,
  input  logic        lookupValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  logic validQ;

  always_comb begin
    strobe.attrWrite  = wrEn & wrLegal;
    strobe.resultLoad = lookupValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= lookupValid;
  end

  assign outValid = validQ;

endmodule

// File: rtl/pat_combiner_datapath.sv
module pat_combiner_datapath
  import pat_combiner_pkg::*;
#(
  parameter int               FLAG_W      = 8,
  parameter int               PWT_BIT     = 3,
  parameter int               PCD_BIT     = 4,
  parameter int               PAT_BIT     = 7,
  parameter logic [REG_W-1:0] RESET_VALUE = 64'h0007040600070406
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [REG_W-1:0]    wrData,
  input  logic [FLAG_W-1:0]   pteFlags,
  input  logic [RANGE_W-1:0]  rangeType,
  output logic                wrLegal,
  output logic [TYPE_W-1:0]   pageType,
  output logic [TYPE_W-1:0]   effType
);

  logic [REG_W-1:0]      attrReg;
  logic [NUM_FIELDS-1:0] fieldOk;
  logic [IDX_W-1:0]      attrIdx;
  logic [TYPE_W-1:0]     selField;
  logic [TYPE_W-1:0]     effNext;
  logic [TYPE_W-1:0]     pageQ;
  logic [TYPE_W-1:0]     effQ;
  logic                  unusedFlagBits;

  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_fieldCheck
    assign fieldOk[n] = typeWritable(wrData[n*TYPE_W +: TYPE_W]);
  end
  assign wrLegal = &fieldOk;

  assign attrIdx        = {pteFlags[PAT_BIT], pteFlags[PCD_BIT], pteFlags[PWT_BIT]};
  assign unusedFlagBits = ^pteFlags;

  always_comb begin
    selField = '0;
    for (int n = 0; n < NUM_FIELDS; n++) begin
      if (attrIdx == IDX_W'(n)) selField = attrReg[n*TYPE_W +: TYPE_W];
    end
  end

  assign effNext = mergeTypes(rangeType, selField);

  always_ff @(posedge clk) begin
    if (!rstN)                 attrReg <= RESET_VALUE;
    else if (strobe.attrWrite) attrReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ <= '0;
      effQ  <= '0;
    end else if (strobe.resultLoad) begin
      pageQ <= selField;
      effQ  <= effNext;
    end
  end

  assign pageType = pageQ;
  assign effType  = effQ;

endmodule

// File: rtl/pat_combiner.sv
module pat_combiner
  import pat_combiner_pkg::*;
#(
  parameter int               FLAG_W      = 8,
  parameter int               PWT_BIT     = 3,
  parameter int               PCD_BIT     = 4,
  parameter int               PAT_BIT     = 7,
  parameter logic [REG_W-1:0] RESET_VALUE = 64'h0007040600070406
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               lookupValid,
  input  logic [FLAG_W-1:0]  pteFlags,
  input  logic [RANGE_W-1:0] rangeType,
  output logic               outValid,
  output logic [TYPE_W-1:0]  pageType,
  output logic [TYPE_W-1:0]  effType
);

  ctrlStrobe_t strobe;
  logic        wrLegal;

  pat_combiner_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrLegal     (wrLegal),
    .lookupValid (lookupValid),
    .strobe      (strobe),
    .outValid    (outValid)
  );

  pat_combiner_datapath #(
    .FLAG_W      (FLAG_W),
    .PWT_BIT     (PWT_BIT),
    .PCD_BIT     (PCD_BIT),
    .PAT_BIT     (PAT_BIT),
    .RESET_VALUE (RESET_VALUE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .pteFlags  (pteFlags),
    .rangeType (rangeType),
    .wrLegal   (wrLegal),
    .pageType  (pageType),
    .effType   (effType)
  );

endmodule

// File: rtl/pat_combiner_checker.sv
module pat_combiner_checker (
  input logic       clk,
  input logic       rstN,
  input logic       lookupValid,
  input logic [2:0] rangeType,
  input logic       outValid,
  input logic [7:0] pageType,
  input logic [7:0] effType
);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> outValid);

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !outValid);

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> ($stable(pageType) && $stable(effType)));

  assert_page_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pageType inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7}));

  assert_reserved_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && (rangeType inside {3'd2, 3'd3, 3'd7})) |=> (effType == 8'd2));

  assert_uc_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && rangeType == 3'd0) |=> (effType == ((pageType == 8'd1) ? 8'd1 : 8'd0)));

  assert_wb_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && rangeType == 3'd6) |=> (effType == ((pageType == 8'd7) ? 8'd0 : pageType)));

endmodule

bind pat_combiner pat_combiner_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .rangeType   (rangeType),
  .outValid    (outValid),
  .pageType    (pageType),
  .effType     (effType)
);

// File: tb/pat_combiner_test.sv
module pat_combiner_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        lookupValid = 1'b0;
  logic [7:0]  pteFlags = '0;
  logic [2:0]  rangeType = '0;
  logic        outValid;
  logic [7:0]  pageType;
  logic [7:0]  effType;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pat_combiner uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .lookupValid(lookupValid), .pteFlags(pteFlags), .rangeType(rangeType),
    .outValid(outValid), .pageType(pageType), .effType(effType)
  );

  localparam logic [63:0] LOADED = 64'h0006070605040100;

  // {range, flags, expected page type, expected effective type} for register LOADED
  localparam logic [26:0] VECS [16] = '{
    {3'd0, 8'h08, 8'd1, 8'd1}, {3'd0, 8'h90, 8'd6, 8'd0},
    {3'd1, 8'h80, 8'd6, 8'd1}, {3'd1, 8'h10, 8'd4, 8'd0},
    {3'd1, 8'h88, 8'd7, 8'd1}, {3'd4, 8'h80, 8'd6, 8'd4},
    {3'd4, 8'h18, 8'd5, 8'd5}, {3'd4, 8'h88, 8'd7, 8'd0},
    {3'd5, 8'h80, 8'd6, 8'd5}, {3'd5, 8'h88, 8'd7, 8'd1},
    {3'd5, 8'h10, 8'd4, 8'd4}, {3'd6, 8'h88, 8'd7, 8'd0},
    {3'd6, 8'h6F, 8'd1, 8'd1}, {3'd2, 8'h80, 8'd6, 8'd2},
    {3'd3, 8'h00, 8'd0, 8'd2}, {3'd7, 8'hE7, 8'd6, 8'd2}
  };

  function automatic logic [7:0] flagsOf(input int idx);
    return {idx[2], 2'b00, idx[1], idx[0], 3'b000};
  endfunction

  function automatic logic [7:0] loadedField(input int idx);
    return LOADED[idx*8 +: 8];
  endfunction

  function automatic logic [7:0] resetField(input int idx);
    case (idx % 4)
      0: return 8'd6;
      1: return 8'd4;
      2: return 8'd7;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] refEff(input logic [2:0] r, input logic [7:0] p);
    if (r == 3'd2 || r == 3'd3 || r == 3'd7 || p == 8'd2 || p == 8'd3 || p > 8'd7) return 8'd2;
    case (r)
      3'd0: return (p == 8'd1) ? 8'd1 : 8'd0;
      3'd1: return (p == 8'd1 || p == 8'd6 || p == 8'd7) ? 8'd1 : 8'd0;
      3'd4: begin
        if (p == 8'd4 || p == 8'd6) return 8'd4;
        if (p == 8'd5) return 8'd5;
        if (p == 8'd1) return 8'd1;
        return 8'd0;
      end
      3'd5: begin
        if (p == 8'd6) return 8'd5;
        if (p == 8'd7) return 8'd1;
        return p;
      end
      default: return (p == 8'd7) ? 8'd0 : p;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] r);
    case (r)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(input logic [2:0] r, input logic [7:0] f);
    @(negedge clk);
    lookupValid = 1'b1;
    rangeType   = r;
    pteFlags    = f;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic writeReg(input logic [63:0] d);
    @(negedge clk);
    wrEn   = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R3: reset state of outputs
    chk("R3 outValid", {7'd0, outValid}, 8'd0);
    chk("R3 pageType", pageType, 8'd0);
    chk("R3 effType", effType, 8'd0);

    // R3, R1, R2: default fields through each index
    for (int i = 0; i < 8; i++) begin
      look(3'd6, flagsOf(i));
      chk("R3 R2 default field", pageType, resetField(i));
      chk("R9 default eff", effType, refEff(3'd6, resetField(i)));
    end

    // R11: valid exactly one cycle, outputs hold
    look(3'd4, flagsOf(1));
    chk("R11 outValid high", {7'd0, outValid}, 8'd1);
    chk("R11 page after lookup", pageType, 8'd4);
    @(negedge clk);
    chk("R11 outValid low", {7'd0, outValid}, 8'd0);
    chk("R11 page held", pageType, 8'd4);
    chk("R11 eff held", effType, 8'd4);

    // R4: legal write accepted
    writeReg(LOADED);

    // vector table, noise on unused flag bits exercises R1
    for (int v = 0; v < 16; v++) begin
      look(VECS[v][26:24], VECS[v][23:16]);
      chk("R1 R2 vector page", pageType, VECS[v][15:8]);
      chk(reqOf(VECS[v][26:24]), effType, VECS[v][7:0]);
    end

    // full sweep of range types against indices
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 8; i++) begin
        look(3'(r), flagsOf(i) | 8'h67);
        chk("R1 sweep page", pageType, loadedField(i));
        chk(reqOf(3'(r)), effType, refEff(3'(r), loadedField(i)));
      end
    end

    // R4: rejected writes leave register unchanged
    writeReg(64'h0006070602040100);
    look(3'd6, flagsOf(3));
    chk("R4 reserved byte rejected", pageType, 8'd5);
    writeReg(64'h8101010101010101);
    look(3'd6, flagsOf(2));
    chk("R4 high byte rejected", pageType, 8'd4);
    look(3'd6, flagsOf(7));
    chk("R4 field 7 unchanged", pageType, 8'd0);

    // R12: write and lookup in the same cycle
    @(negedge clk);
    wrEn        = 1'b1;
    wrData      = 64'h0101010101010101;
    lookupValid = 1'b1;
    rangeType   = 3'd6;
    pteFlags    = flagsOf(4);
    @(negedge clk);
    wrEn        = 1'b0;
    lookupValid = 1'b0;
    chk("R12 old field used", pageType, 8'd6);
    chk("R12 old eff", effType, 8'd6);
    look(3'd6, flagsOf(4));
    chk("R12 new field after", pageType, 8'd1);
    chk("R4 accepted write", effType, 8'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule